// File: doc/BRIEF.md
# Omega Multistage Switching Network

This block joins P source ports to P destination ports, with P a power of two (eight by default). Packets move through log2(P) columns of 2x2 switching elements, and each column is fed through a perfect-shuffle permutation. Each packet carries a valid bit, a destination label and a payload. The network attaches the source label itself, taken from the input port number.

Every 2x2 element sets itself for each packet without any central control. At column s it looks at label bit (log2(P)-1-s), so the first column uses the most significant bit. If that bit has the same value in the source label and the destination label, the packet passes straight through. If the values differ, the packet crosses over.

The network can block. When two packets at one element want the same output in the same cycle, the packet on the upper input wins. The other packet is dropped, and its source is told through a one-cycle blocked flag. Each column can be registered, so a complete set of packets can be injected on every clock.

Top module: `omega_net`

## Requirements
- R1: While reset is held low and on the first clock after it, every bit of out_valid and blocked is 0.
- R2: With the default registered columns, a valid packet injected at input port k leaves on output port d exactly log2(P) clock edges after it is sampled, where d is its destination label. On that port, out_src carries k and out_data carries the injected payload unchanged.
- R3: Column s (s = 0 first) compares label bit (log2(P)-1-s) of the source and the destination. It passes the packet straight when the two bits are equal and crosses it over when they differ. As a result, a lone packet reaches its destination from every one of the P*P source and destination pairs.
- R4: In the uniform-shift patterns, every input is valid and input k targets (k+c) mod P. Every packet of such a pattern is delivered and none is blocked.
- R5: When two valid packets at one element request the same output, the packet on the upper input wins and the other is dropped. The upper input is the one whose examined source bit is 0. Examples: sources 0 and 4 sent to destination 1 deliver source 0. Sources 0 and 2 sent to destination 0 clash in the second column and deliver source 0.
- R6: A dropped packet from input k raises blocked[k] for exactly one cycle, in the cycle its delivery would have occurred (log2(P) edges after injection). It appears on no output.
- R7: Every valid packet leaves exactly once, either delivered or blocked. Inputs with in_valid low produce nothing, and their destination and payload fields do not change any switch setting.
- R8: New packet sets may be injected on consecutive cycles, and each set is routed independently of its neighbours.
- R9: In any cycle where some blocked bit is set, at least one output carries a delivered packet.
- R10: A packet injected alone is never blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | P | Per-input packet valid |
| in_dst | input | P*log2(P) | Destination label per input; input k uses bits [k*log2(P) +: log2(P)] |
| in_data | input | P*DW | Payload per input; input k uses bits [k*DW +: DW] |
| out_valid | output | P | Per-output delivered valid |
| out_src | output | P*log2(P) | Source label of the packet on each output |
| out_data | output | P*DW | Payload on each output |
| blocked | output | P | Per-source flag for a dropped packet |

## Verification
In a contended cycle, the winner's delivery and the loser's blocked flag come out on the same clock, on different ports. The bench forces this in three ways: source pairs that clash in the first column (0 and 4), source pairs that clash only in the second column (0 and 2), and long runs of random full-load patterns injected back to back. An independent model follows each packet's line label column by column and settles each clash by the examined source bit. The scoreboard then compares the whole output and blocked vectors cycle by cycle, which shows that the winner lands and the loser is reported in that same cycle.

// File: rtl/omega_pkg.sv
// Package: shared types and index helpers for the omega network.
// Assumes port counts are powers of two so a rotation stays in range.
package omega_pkg;

    // Setting chosen by one 2x2 element for one packet.
    typedef enum logic {
        SW_STRAIGHT = 1'b0,
        SW_CROSS    = 1'b1
    } sw_set_e;

    // Perfect shuffle: rotate an nbits-wide index left by one bit.
    function automatic int shuffle_idx(input int idx, input int nbits);
        int msk;
        msk = (1 << nbits) - 1;
        return ((idx << 1) | (idx >> (nbits - 1))) & msk;
    endfunction

endpackage

// File: rtl/omega_switch2.sv
// Module: omega_switch2
// One 2x2 self-routing element, purely combinational. It examines label
// bit BITSEL of each packet: straight if source and destination agree,
// crossed if they differ. If both inputs want the same output, the
// upper input (index 0) keeps it and the lower packet is dropped.
// Assumes the lower input is the one whose examined source bit is 1.
module omega_switch2
    import omega_pkg::*;
#(
    parameter int NB     = 3,
    parameter int DW     = 8,
    parameter int BITSEL = 2
) (
    input  logic [1:0]                in_v,
    input  logic [1:0][NB-1:0]        in_src,
    input  logic [1:0][NB-1:0]        in_dst,
    input  logic [1:0][DW-1:0]        in_data,
    output logic [1:0]                out_v,
    output logic [1:0][NB-1:0]        out_src,
    output logic [1:0][NB-1:0]        out_dst,
    output logic [1:0][DW-1:0]        out_data,
    output logic                      drop_lo
);

    sw_set_e set_up;
    sw_set_e set_lo;
    logic    req_up;
    logic    req_lo;
    logic    clash;

    // Decide each packet's setting and the output it asks for.
    always_comb begin
        set_up = (in_src[0][BITSEL] == in_dst[0][BITSEL]) ? SW_STRAIGHT : SW_CROSS;
        set_lo = (in_src[1][BITSEL] == in_dst[1][BITSEL]) ? SW_STRAIGHT : SW_CROSS;
        req_up = (set_up == SW_CROSS);
        req_lo = (set_lo == SW_STRAIGHT);
        clash  = in_v[0] && in_v[1] && (req_up == req_lo);
    end

    // Steer the surviving packets onto their requested outputs.
    always_comb begin
        out_v    = '0;
        out_src  = '0;
        out_dst  = '0;
        out_data = '0;
        if (in_v[0]) begin
            out_v[req_up]    = 1'b1;
            out_src[req_up]  = in_src[0];
            out_dst[req_up]  = in_dst[0];
            out_data[req_up] = in_data[0];
        end
        if (in_v[1] && !clash) begin
            out_v[req_lo]    = 1'b1;
            out_src[req_lo]  = in_src[1];
            out_dst[req_lo]  = in_dst[1];
            out_data[req_lo] = in_data[1];
        end
    end

    assign drop_lo = clash;

endmodule

// File: rtl/omega_stage.sv
// Module: omega_stage
// One column: perfect shuffle of P lines, P/2 elements examining bit
// (NB-1-STG), and a per-source drop vector merged with the one arriving
// from upstream. PIPE=1 registers the column; PIPE=0 leaves it open.
// Assumes P = 2**NB.
module omega_stage
    import omega_pkg::*;
#(
    parameter int P    = 8,
    parameter int NB   = 3,
    parameter int DW   = 8,
    parameter int STG  = 0,
    parameter int PIPE = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [P-1:0]               up_v,
    input  logic [P-1:0][NB-1:0]       up_src,
    input  logic [P-1:0][NB-1:0]       up_dst,
    input  logic [P-1:0][DW-1:0]       up_data,
    input  logic [P-1:0]               up_blk,
    output logic [P-1:0]               dn_v,
    output logic [P-1:0][NB-1:0]       dn_src,
    output logic [P-1:0][NB-1:0]       dn_dst,
    output logic [P-1:0][DW-1:0]       dn_data,
    output logic [P-1:0]               dn_blk
);

    localparam int NSW    = P / 2;
    localparam int BITSEL = NB - 1 - STG;

    logic [P-1:0]         sh_v;
    logic [P-1:0][NB-1:0] sh_src;
    logic [P-1:0][NB-1:0] sh_dst;
    logic [P-1:0][DW-1:0] sh_data;
    logic [P-1:0]         sw_v;
    logic [P-1:0][NB-1:0] sw_src;
    logic [P-1:0][NB-1:0] sw_dst;
    logic [P-1:0][DW-1:0] sw_data;
    logic [NSW-1:0]       drop;
    logic [P-1:0]         nxt_blk;

    // Perfect-shuffle wiring in front of the element column.
    always_comb begin
        sh_v    = '0;
        sh_src  = '0;
        sh_dst  = '0;
        sh_data = '0;
        for (int k = 0; k < P; k++) begin
            sh_v[shuffle_idx(k, NB)]    = up_v[k];
            sh_src[shuffle_idx(k, NB)]  = up_src[k];
            sh_dst[shuffle_idx(k, NB)]  = up_dst[k];
            sh_data[shuffle_idx(k, NB)] = up_data[k];
        end
    end

    // Column of 2x2 elements on line pairs (2i, 2i+1).
    for (genvar sw = 0; sw < NSW; sw++) begin : g_sw
        omega_switch2 #(
            .NB     (NB),
            .DW     (DW),
            .BITSEL (BITSEL)
        ) u_sw (
            .in_v     (sh_v[2*sw+1:2*sw]),
            .in_src   (sh_src[2*sw+1:2*sw]),
            .in_dst   (sh_dst[2*sw+1:2*sw]),
            .in_data  (sh_data[2*sw+1:2*sw]),
            .out_v    (sw_v[2*sw+1:2*sw]),
            .out_src  (sw_src[2*sw+1:2*sw]),
            .out_dst  (sw_dst[2*sw+1:2*sw]),
            .out_data (sw_data[2*sw+1:2*sw]),
            .drop_lo  (drop[sw])
        );
    end

    // Mark the source of every packet dropped in this column.
    always_comb begin
        nxt_blk = up_blk;
        for (int sw = 0; sw < NSW; sw++) begin
            if (drop[sw]) nxt_blk[sh_src[2*sw+1]] = 1'b1;
        end
    end

    if (PIPE != 0) begin : g_reg
        // Column register; reset clears valids and drop flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dn_v    <= '0;
                dn_src  <= '0;
                dn_dst  <= '0;
                dn_data <= '0;
                dn_blk  <= '0;
            end else begin
                dn_v    <= sw_v;
                dn_src  <= sw_src;
                dn_dst  <= sw_dst;
                dn_data <= sw_data;
                dn_blk  <= nxt_blk;
            end
        end
    end else begin : g_comb
        // Unregistered column: pass the element outputs through.
        always_comb begin
            dn_v    = sw_v;
            dn_src  = sw_src;
            dn_dst  = sw_dst;
            dn_data = sw_data;
            dn_blk  = nxt_blk;
        end
    end

endmodule

// File: rtl/omega_net.sv
// Module: omega_net
// Top of the self-routing omega network: log2(P) shuffle-plus-element
// columns in a chain. The source label is taken from the input port
// number. A delivered packet leaves on the port equal to its destination
// label; a dropped one raises blocked at its source index in the cycle
// it would have been delivered. Assumes P is a power of two, P >= 2.
module omega_net #(
    parameter int P    = 8,
    parameter int DW   = 8,
    parameter int PIPE = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [P-1:0]                in_valid,
    input  logic [P*$clog2(P)-1:0]      in_dst,
    input  logic [P*DW-1:0]             in_data,
    output logic [P-1:0]                out_valid,
    output logic [P*$clog2(P)-1:0]      out_src,
    output logic [P*DW-1:0]             out_data,
    output logic [P-1:0]                blocked
);

    localparam int NB = $clog2(P);

    logic [NB:0][P-1:0]         ch_v;
    logic [NB:0][P-1:0][NB-1:0] ch_src;
    logic [NB:0][P-1:0][NB-1:0] ch_dst;
    logic [NB:0][P-1:0][DW-1:0] ch_data;
    logic [NB:0][P-1:0]         ch_blk;

    // Head of the chain: unpack the inputs and stamp the source labels.
    for (genvar k = 0; k < P; k++) begin : g_head
        assign ch_v[0][k]    = in_valid[k];
        assign ch_src[0][k]  = NB'(k);
        assign ch_dst[0][k]  = in_dst[k*NB +: NB];
        assign ch_data[0][k] = in_data[k*DW +: DW];
        assign ch_blk[0][k]  = 1'b0;
    end

    // Column chain; column s examines label bit NB-1-s.
    for (genvar s = 0; s < NB; s++) begin : g_col
        omega_stage #(
            .P    (P),
            .NB   (NB),
            .DW   (DW),
            .STG  (s),
            .PIPE (PIPE)
        ) u_col (
            .clk     (clk),
            .rst_n   (rst_n),
            .up_v    (ch_v[s]),
            .up_src  (ch_src[s]),
            .up_dst  (ch_dst[s]),
            .up_data (ch_data[s]),
            .up_blk  (ch_blk[s]),
            .dn_v    (ch_v[s+1]),
            .dn_src  (ch_src[s+1]),
            .dn_dst  (ch_dst[s+1]),
            .dn_data (ch_data[s+1]),
            .dn_blk  (ch_blk[s+1])
        );
    end

    // Tail of the chain: flatten onto the output ports.
    for (genvar j = 0; j < P; j++) begin : g_tail
        assign out_src[j*NB +: NB]  = ch_src[NB][j];
        assign out_data[j*DW +: DW] = ch_data[NB][j];
    end
    assign out_valid = ch_v[NB];
    assign blocked   = ch_blk[NB];

endmodule

// File: rtl/omega_net_chk.sv
// Module: omega_net_chk
// Property checker bound to omega_net. It tracks the number of injected
// packets through a latency-matched counter pipeline and checks
// conservation, reset, landing port and blocking rules.
module omega_net_chk #(
    parameter int P    = 8,
    parameter int DW   = 8,
    parameter int PIPE = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [P-1:0]                in_valid,
    input  logic [P-1:0]                out_valid,
    input  logic [P-1:0]                blocked,
    input  logic [P-1:0][$clog2(P)-1:0] fin_dst
);

    localparam int NB  = $clog2(P);
    localparam int LAT = (PIPE != 0) ? NB : 0;

    logic [NB:0] exp_cnt;

    if (LAT == 0) begin : g_nolat
        assign exp_cnt = (NB+1)'($countones(in_valid));
    end else begin : g_lat
        logic [NB:0] cnt_q [LAT];
        // Delay the injected-packet count by the network latency.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < LAT; i++) cnt_q[i] <= '0;
            end else begin
                cnt_q[0] <= (NB+1)'($countones(in_valid));
                for (int i = 1; i < LAT; i++) cnt_q[i] <= cnt_q[i-1];
            end
        end
        assign exp_cnt = cnt_q[LAT-1];

        assert_reset_clear_R1: assert property (@(posedge clk)
            !rst_n |=> (out_valid == '0 && blocked == '0));
    end

    assert_conserve_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(out_valid) + $countones(blocked)) == int'(exp_cnt));

    assert_blk_has_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked != '0) |-> (out_valid != '0));

    assert_lone_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_cnt == 1) |-> (blocked == '0));

    for (genvar j = 0; j < P; j++) begin : g_land
        assert_land_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j] |-> (fin_dst[j] == NB'(j)));
    end

endmodule

bind omega_net omega_net_chk #(
    .P    (P),
    .DW   (DW),
    .PIPE (PIPE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .blocked   (blocked),
    .fin_dst   (ch_dst[$clog2(P)])
);

// File: tb/tb_omega_net.sv
`timescale 1ns/1ps
// Scoreboard bench for omega_net at default parameters (P=8, DW=8).
module tb_omega_net;

    localparam int P  = 8;
    localparam int NB = 3;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [P-1:0]      in_valid = '0;
    logic [P*NB-1:0]   in_dst = '0;
    logic [P*DW-1:0]   in_data = '0;
    logic [P-1:0]      out_valid;
    logic [P*NB-1:0]   out_src;
    logic [P*DW-1:0]   out_data;
    logic [P-1:0]      blocked;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    typedef struct {
        int                   due;
        logic [P-1:0]         v;
        logic [P-1:0]         blk;
        logic [P-1:0][NB-1:0] src;
        logic [P-1:0][DW-1:0] data;
        string                tag;
    } exp_t;

    exp_t q[$];

    omega_net dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dst    (in_dst),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_src   (out_src),
        .out_data  (out_data),
        .blocked   (blocked)
    );

    always #2.5 clk = ~clk;

    function automatic void chk(input bit ok, input string tag, input string what,
                                input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endfunction

    // Driver: drive one packet set at a falling edge and push its expectation.
    task automatic send(input logic [P-1:0] v, input logic [P-1:0][NB-1:0] d,
                        input logic [P-1:0][DW-1:0] dat, input string tag);
        exp_t e;
        logic [P-1:0] alive;
        int line [P];
        e.v = '0; e.blk = '0; e.src = '0; e.data = '0; e.tag = tag;
        alive = v;
        for (int st = 0; st < NB; st++) begin
            for (int k = 0; k < P; k++)
                line[k] = ((k << (st + 1)) | (int'(d[k]) >> (NB - 1 - st))) & (P - 1);
            for (int k = 0; k < P; k++)
                for (int m = k + 1; m < P; m++)
                    if (alive[k] && alive[m] && line[k] == line[m]) begin
                        if (((k >> (NB - 1 - st)) & 1) == 1) begin
                            alive[k] = 1'b0; e.blk[k] = 1'b1;
                        end else begin
                            alive[m] = 1'b0; e.blk[m] = 1'b1;
                        end
                    end
        end
        for (int k = 0; k < P; k++)
            if (alive[k]) begin
                e.v[d[k]]    = 1'b1;
                e.src[d[k]]  = NB'(k);
                e.data[d[k]] = dat[k];
            end
        @(negedge clk);
        in_valid = v;
        in_dst   = d;
        in_data  = dat;
        e.due    = cyc + NB;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send('0, '0, '0, "R7 R6 idle");
    endtask

    // Monitor: pop the expectation due this cycle and compare.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            while (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(out_valid == e.v, e.tag, "out_valid", int'(out_valid), int'(e.v));
                chk(blocked == e.blk, e.tag, "blocked", int'(blocked), int'(e.blk));
                for (int j = 0; j < P; j++)
                    if (e.v[j] && out_valid[j]) begin
                        chk(out_src[j*NB +: NB] == e.src[j], e.tag, "out_src",
                            int'(out_src[j*NB +: NB]), int'(e.src[j]));
                        chk(out_data[j*DW +: DW] == e.data[j], e.tag, "out_data",
                            int'(out_data[j*DW +: DW]), int'(e.data[j]));
                    end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [P-1:0][NB-1:0] d;
        logic [P-1:0][DW-1:0] dat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet under reset
        chk(out_valid == '0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(blocked == '0, "R1", "blocked in reset", int'(blocked), 0);
        rst_n = 1'b1;

        // R2 R3 R10: every lone source/destination pair
        for (int s = 0; s < P; s++)
            for (int t = 0; t < P; t++) begin
                d = '0; dat = '0;
                d[s] = NB'(t);
                dat[s] = DW'($urandom);
                send(P'(1) << s, d, dat, "R2 R3 R10 lone");
            end
        idle(2);

        // R4: uniform shifts, all inputs loaded
        for (int c = 0; c < P; c++) begin
            for (int k = 0; k < P; k++) begin
                d[k] = NB'((k + c) % P);
                dat[k] = DW'($urandom);
            end
            send('1, d, dat, "R4 shift");
        end
        idle(2);

        // R5 R6 R9: first-column clash, sources 0 and 4 to destination 1
        d = '0; dat = '0;
        d[0] = 3'd1; d[4] = 3'd1; dat[0] = 8'hA0; dat[4] = 8'hB4;
        send(8'h11, d, dat, "R5 R6 R9 clash col0 dst1");
        d[0] = 3'd5; d[4] = 3'd5;
        send(8'h11, d, dat, "R5 R6 R9 clash col0 dst5");
        // R5 R6 R9: second-column clash, sources 0 and 2 to destination 0
        d = '0; dat = '0;
        dat[0] = 8'h5A; dat[2] = 8'hC2;
        send(8'h05, d, dat, "R5 R6 R9 clash col1");
        idle(2);

        // R7: invalid inputs ignored even when their labels would clash
        d = '0; dat = '0;
        for (int k = 0; k < P; k++) d[k] = 3'd1;
        dat[0] = 8'hEE; dat[4] = 8'h44;
        send(8'h10, d, dat, "R7 invalid ignored");
        idle(2);

        // R7 R8 R9: random loads back to back
        for (int i = 0; i < 300; i++) begin
            for (int k = 0; k < P; k++) begin
                d[k] = NB'($urandom);
                dat[k] = DW'($urandom);
            end
            send(P'($urandom), d, dat, "R7 R8 R9 random");
        end
        idle(NB + 2);

        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule